// File: doc/BRIEF.md
# Open-Row-Aware DRAM Request Scheduler

This block keeps a small pool of pending memory reads and writes and, in every cycle, picks one of them for the DRAM command stage that follows it. Each pooled request names a bank, a row, a column and a direction. The block tracks which row is open in each bank, so it knows what the chosen request needs next: an activate for a closed bank, a precharge for a bank holding another row, or a column read or write once its row is open. Only a column access retires the request. Activates and precharges leave the request in the pool until its row is open.

All pooled requests compete in the same cycle. Ranking follows a fixed ladder, from highest to lowest: requests that have waited longer than a programmable limit; reads to an open row; other reads; writes to an open row; other writes. Inside a rung the oldest request wins. Writes therefore go out only in slots where no read can, and no fill level forces a burst of writes. Each bank has a down-counter that is loaded with a programmable value whenever the bank takes a command. The bank is blocked while its counter runs, and commands to other banks keep flowing in that time.

Both data ports are valid/ready streams. A request is taken on any edge where `req_valid` and `req_ready` are both high, and `req_ready` depends only on the pool having a free slot. On the command side an offer that is not taken is held: while `cmd_valid` is high and `cmd_ready` is low, the next cycle offers the same tag, kind and fields again. The downstream stage may hold `cmd_ready` low for as long as it needs. `cfg_busy` and `cfg_age_limit` are plain static controls.

Top module: `dram_sched`

## Requirements
- R1: `req_ready` is high exactly when at least one of the DEPTH slots is free. A request is stored on an edge with `req_valid` and `req_ready` both high, in the lowest-numbered free slot, and that slot index is its `cmd_tag`.
- R2: `cmd_kind` encodes the next step for the offered request: 0 activate (bank closed), 1 precharge (bank open on a different row), 2 column read and 3 column write (bank open on the request's row). `cmd_bank`, `cmd_row` and `cmd_col` carry the request's own fields.
- R3: An accepted activate opens its bank on `cmd_row`. An accepted precharge closes the bank. An accepted column access removes the request, so its slot is free in the next cycle.
- R4: Every accepted command loads its bank's counter with `cfg_busy`, and the counter falls by one each cycle until it reaches zero. A request is eligible only while its bank's counter is zero, and `cmd_valid` is high whenever some pooled request is eligible.
- R5: Among eligible reads that are not aged, a read whose row is already open is offered before any read that needs a row change.
- R6: A write that is not aged is offered only when no read is eligible. Among such writes, open-row hits go first.
- R7: Inside one rank the oldest request wins. A request's age counts the cycles since it was accepted and saturates at 2^AGE_W-1. Equal ages go to the lower slot index.
- R8: A request whose age exceeds `cfg_age_limit` ranks above every other rank.
- R9: When `cmd_valid` is high and `cmd_ready` is low, the next cycle offers the same tag, kind, bank, row and column.
- R10: While one bank's counter is running, a command for another bank may be offered and accepted.
- R11: After reset the pool is empty, all banks are closed with their counters at zero, `cmd_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_busy | input | BUSY_W | Cycles a bank stays blocked after a command |
| cfg_age_limit | input | AGE_W | Age above which a request is promoted |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Pool has a free slot |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Request bank |
| req_row | input | ROW_W | Request row |
| req_col | input | COL_W | Request column |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Command stage takes the offer |
| cmd_kind | output | 2 | 0 activate, 1 precharge, 2 read, 3 write |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_row | output | ROW_W | Row of the request |
| cmd_col | output | COL_W | Column of the request |
| cmd_tag | output | log2(DEPTH) | Pool slot of the request |

## Verification
The bench keeps the default eight slots and eight banks but narrows the age counter to six bits and the busy counter to three bits. That way age saturation and the promotion limit are reached within a few dozen cycles, and every busy setting from 0 to 3 gets tried. Random traffic is confined to four banks and three rows, so open-row hits, row conflicts and several requests to one bank happen all the time. A random `cmd_ready` keeps the hold rule under test throughout. Each phase switches to a new busy value and a new age limit, and the limits run from a tight one, where promotion dominates, to one large enough to leave the plain ranking in charge.

// File: rtl/dram_sched_pkg.sv
`timescale 1ns/1ps
package dram_sched_pkg;
  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_PRE = 2'd1,
    CMD_RD  = 2'd2,
    CMD_WR  = 2'd3
  } cmd_kind_e;

  // rank ladder, larger wins
  localparam logic [2:0] RANK_WR_MISS = 3'd0;
  localparam logic [2:0] RANK_WR_HIT  = 3'd1;
  localparam logic [2:0] RANK_RD_MISS = 3'd2;
  localparam logic [2:0] RANK_RD_HIT  = 3'd3;
  localparam logic [2:0] RANK_AGED    = 3'd4;
endpackage

// File: rtl/sched_pool.sv
`timescale 1ns/1ps
// Request slots with per-slot age (R1, R3, R7)
module sched_pool #(
  parameter int DEPTH  = 8,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int COL_W  = 10,
  parameter int AGE_W  = 8,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic              alloc_write,
  input  logic [BANK_W-1:0] alloc_bank,
  input  logic [ROW_W-1:0]  alloc_row,
  input  logic [COL_W-1:0]  alloc_col,
  input  logic              retire_en,
  input  logic [TAG_W-1:0]  retire_idx,
  output logic              has_free,
  output logic [DEPTH-1:0]  ent_v,
  output logic [DEPTH-1:0]  ent_w,
  output logic [BANK_W-1:0] ent_bank [DEPTH],
  output logic [ROW_W-1:0]  ent_row  [DEPTH],
  output logic [COL_W-1:0]  ent_col  [DEPTH],
  output logic [AGE_W-1:0]  ent_age  [DEPTH]
);
  logic [TAG_W-1:0] free_idx;

  assign has_free = ~&ent_v;

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!ent_v[i]) free_idx = TAG_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v <= '0;
      ent_w <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        ent_bank[i] <= '0;
        ent_row[i]  <= '0;
        ent_col[i]  <= '0;
        ent_age[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (retire_en && retire_idx == TAG_W'(i)) begin
          ent_v[i] <= 1'b0;
        end else if (alloc_en && free_idx == TAG_W'(i)) begin
          ent_v[i]    <= 1'b1;
          ent_w[i]    <= alloc_write;
          ent_bank[i] <= alloc_bank;
          ent_row[i]  <= alloc_row;
          ent_col[i]  <= alloc_col;
          ent_age[i]  <= '0;
        end else if (ent_v[i] && ent_age[i] != '1) begin
          ent_age[i] <= ent_age[i] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sched_banks.sv
`timescale 1ns/1ps
// Per-bank open row and busy counter (R3, R4)
module sched_banks
  import dram_sched_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int BUSY_W = 4,
  localparam int BANKS = 1 << BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUSY_W-1:0] cfg_busy,
  input  logic              upd_en,
  input  logic [BANK_W-1:0] upd_bank,
  input  logic [1:0]        upd_kind,
  input  logic [ROW_W-1:0]  upd_row,
  output logic [BANKS-1:0]  bank_open,
  output logic [ROW_W-1:0]  bank_row [BANKS],
  output logic [BANKS-1:0]  bank_idle
);
  logic [BUSY_W-1:0] busy_cnt [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign bank_idle[b] = (busy_cnt[b] == '0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank_open[b] <= 1'b0;
        bank_row[b]  <= '0;
        busy_cnt[b]  <= '0;
      end else if (upd_en && upd_bank == BANK_W'(b)) begin
        busy_cnt[b] <= cfg_busy;
        if (upd_kind == CMD_ACT) begin
          bank_open[b] <= 1'b1;
          bank_row[b]  <= upd_row;
        end else if (upd_kind == CMD_PRE) begin
          bank_open[b] <= 1'b0;
        end
      end else if (busy_cnt[b] != '0) begin
        busy_cnt[b] <= busy_cnt[b] - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sched_picker.sv
`timescale 1ns/1ps
// Parallel ranking of all slots (R2, R5, R6, R7, R8)
module sched_picker
  import dram_sched_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int AGE_W  = 8,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int BANKS = 1 << BANK_W,
  localparam int SCORE_W = 3 + AGE_W
) (
  input  logic [DEPTH-1:0]  ent_v,
  input  logic [DEPTH-1:0]  ent_w,
  input  logic [BANK_W-1:0] ent_bank [DEPTH],
  input  logic [ROW_W-1:0]  ent_row  [DEPTH],
  input  logic [AGE_W-1:0]  ent_age  [DEPTH],
  input  logic [BANKS-1:0]  bank_open,
  input  logic [ROW_W-1:0]  bank_row [BANKS],
  input  logic [BANKS-1:0]  bank_idle,
  input  logic [AGE_W-1:0]  age_limit,
  output logic [1:0]        ent_kind [DEPTH],
  output logic              pick_v,
  output logic [TAG_W-1:0]  pick_idx
);
  logic [DEPTH-1:0] elig;
  logic [DEPTH-1:0] hit;
  logic [DEPTH-1:0] opn;
  logic [2:0]       rank [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign opn[i]  = bank_open[ent_bank[i]];
    assign hit[i]  = opn[i] && (bank_row[ent_bank[i]] == ent_row[i]);
    assign elig[i] = ent_v[i] && bank_idle[ent_bank[i]];
    assign ent_kind[i] = !opn[i] ? CMD_ACT :
                         !hit[i] ? CMD_PRE :
                         ent_w[i] ? CMD_WR : CMD_RD;
    assign rank[i] = (ent_age[i] > age_limit) ? RANK_AGED :
                     !ent_w[i] ? (hit[i] ? RANK_RD_HIT : RANK_RD_MISS) :
                                 (hit[i] ? RANK_WR_HIT : RANK_WR_MISS);
  end

  logic [SCORE_W-1:0] best_s;

  always_comb begin
    pick_v   = 1'b0;
    pick_idx = '0;
    best_s   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (elig[i] && (!pick_v || {rank[i], ent_age[i]} > best_s)) begin
        pick_v   = 1'b1;
        pick_idx = TAG_W'(i);
        best_s   = {rank[i], ent_age[i]};
      end
    end
  end
endmodule

// File: rtl/dram_sched.sv
`timescale 1ns/1ps
// Top: pool, bank state, picker and command hold register (R9)
module dram_sched
  import dram_sched_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int COL_W  = 10,
  parameter int AGE_W  = 8,
  parameter int BUSY_W = 4,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int BANKS = 1 << BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUSY_W-1:0] cfg_busy,
  input  logic [AGE_W-1:0]  cfg_age_limit,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_kind,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col,
  output logic [TAG_W-1:0]  cmd_tag
);
  logic [DEPTH-1:0]  ent_v, ent_w;
  logic [BANK_W-1:0] ent_bank [DEPTH];
  logic [ROW_W-1:0]  ent_row  [DEPTH];
  logic [COL_W-1:0]  ent_col  [DEPTH];
  logic [AGE_W-1:0]  ent_age  [DEPTH];
  logic [1:0]        ent_kind [DEPTH];
  logic [BANKS-1:0]  bank_open, bank_idle;
  logic [ROW_W-1:0]  bank_row [BANKS];
  logic              pick_v, hold_v, fire;
  logic [TAG_W-1:0]  pick_idx, hold_idx, sel_idx;

  assign sel_idx   = hold_v ? hold_idx : pick_idx;
  assign cmd_valid = hold_v | pick_v;
  assign cmd_tag   = sel_idx;
  assign cmd_kind  = ent_kind[sel_idx];
  assign cmd_bank  = ent_bank[sel_idx];
  assign cmd_row   = ent_row[sel_idx];
  assign cmd_col   = ent_col[sel_idx];
  assign fire      = cmd_valid & cmd_ready;

  sched_pool #(
    .DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .AGE_W(AGE_W)
  ) u_pool (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_en   (req_valid & req_ready),
    .alloc_write(req_write),
    .alloc_bank (req_bank),
    .alloc_row  (req_row),
    .alloc_col  (req_col),
    .retire_en  (fire & cmd_kind[1]),
    .retire_idx (sel_idx),
    .has_free   (req_ready),
    .ent_v      (ent_v),
    .ent_w      (ent_w),
    .ent_bank   (ent_bank),
    .ent_row    (ent_row),
    .ent_col    (ent_col),
    .ent_age    (ent_age)
  );

  sched_banks #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .BUSY_W(BUSY_W)
  ) u_banks (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_busy (cfg_busy),
    .upd_en   (fire),
    .upd_bank (cmd_bank),
    .upd_kind (cmd_kind),
    .upd_row  (cmd_row),
    .bank_open(bank_open),
    .bank_row (bank_row),
    .bank_idle(bank_idle)
  );

  sched_picker #(
    .DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .AGE_W(AGE_W)
  ) u_picker (
    .ent_v    (ent_v),
    .ent_w    (ent_w),
    .ent_bank (ent_bank),
    .ent_row  (ent_row),
    .ent_age  (ent_age),
    .bank_open(bank_open),
    .bank_row (bank_row),
    .bank_idle(bank_idle),
    .age_limit(cfg_age_limit),
    .ent_kind (ent_kind),
    .pick_v   (pick_v),
    .pick_idx (pick_idx)
  );

  // R9: an offer that was not taken is repeated
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v   <= 1'b0;
      hold_idx <= '0;
    end else begin
      hold_v   <= cmd_valid & ~cmd_ready;
      hold_idx <= sel_idx;
    end
  end
endmodule

// File: rtl/dram_sched_chk.sv
`timescale 1ns/1ps
module dram_sched_chk #(
  parameter int DEPTH  = 8,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int BUSY_W = 4,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int BANKS = 1 << BANK_W,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BUSY_W-1:0] cfg_busy,
  input logic              req_valid,
  input logic              req_ready,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_kind,
  input logic [BANK_W-1:0] cmd_bank,
  input logic [ROW_W-1:0]  cmd_row,
  input logic [TAG_W-1:0]  cmd_tag
);
  logic [BANKS-1:0] sh_open;
  logic [ROW_W-1:0] sh_row [BANKS];
  logic [OCC_W-1:0] occ;
  logic             acc, fire;

  assign acc  = req_valid & req_ready;
  assign fire = cmd_valid & cmd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ     <= '0;
      sh_open <= '0;
      for (int b = 0; b < BANKS; b++) sh_row[b] <= '0;
    end else begin
      occ <= occ + OCC_W'(acc) - OCC_W'(fire & cmd_kind[1]);
      if (fire && cmd_kind == 2'd0) begin
        sh_open[cmd_bank] <= 1'b1;
        sh_row[cmd_bank]  <= cmd_row;
      end else if (fire && cmd_kind == 2'd1) begin
        sh_open[cmd_bank] <= 1'b0;
      end
    end
  end

  p_ready_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready == (occ != OCC_W'(DEPTH)));

  p_act_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == 2'd0) |-> !sh_open[cmd_bank]);

  p_pre_conflict_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == 2'd1) |-> (sh_open[cmd_bank] && sh_row[cmd_bank] != cmd_row));

  p_col_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind[1]) |-> (sh_open[cmd_bank] && sh_row[cmd_bank] == cmd_row));

  p_busy_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cfg_busy != '0) |=> !(cmd_valid && cmd_bank == $past(cmd_bank)));

  p_hold_offer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_tag) && $stable(cmd_kind)
                                   && $stable(cmd_bank) && $stable(cmd_row)));
endmodule

bind dram_sched dram_sched_chk #(
  .DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .BUSY_W(BUSY_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_busy (cfg_busy),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready),
  .cmd_kind (cmd_kind),
  .cmd_bank (cmd_bank),
  .cmd_row  (cmd_row),
  .cmd_tag  (cmd_tag)
);

// File: tb/dram_sched_bench.sv
`timescale 1ns/1ps
module dram_sched_bench;
  localparam int DEPTH = 8, BANK_W = 3, ROW_W = 14, COL_W = 10;
  localparam int AGE_W = 6, BUSY_W = 3, TAG_W = 3, BANKS = 8;
  localparam int AGE_MAX = (1 << AGE_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [BUSY_W-1:0] cfg_busy = '0;
  logic [AGE_W-1:0]  cfg_age_limit = '1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [BANK_W-1:0] req_bank = '0;
  logic [ROW_W-1:0]  req_row = '0;
  logic [COL_W-1:0]  req_col = '0;
  logic cmd_ready = 1'b0;
  logic req_ready, cmd_valid;
  logic [1:0] cmd_kind;
  logic [BANK_W-1:0] cmd_bank;
  logic [ROW_W-1:0]  cmd_row;
  logic [COL_W-1:0]  cmd_col;
  logic [TAG_W-1:0]  cmd_tag;

  dram_sched #(
    .DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .AGE_W(AGE_W), .BUSY_W(BUSY_W)
  ) u_dram_sched (
    .clk(clk), .rst_n(rst_n), .cfg_busy(cfg_busy), .cfg_age_limit(cfg_age_limit),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_tag(cmd_tag)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;

  // expected-behaviour model state
  bit mv[DEPTH]; bit mw[DEPTH];
  int mb[DEPTH]; int mr[DEPTH]; int mc[DEPTH]; int ma[DEPTH];
  bit bo[BANKS]; int br[BANKS]; int bbusy[BANKS];
  bit hv; int hi;
  int nb = 0, nl = AGE_MAX;          // settings to drive
  int e_valid, e_idx, e_kind; string e_why;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int kind_of(input int i);
    if (!bo[mb[i]]) return 0;
    if (br[mb[i]] != mr[i]) return 1;
    return mw[i] ? 3 : 2;
  endfunction

  function automatic int rank_of(input int i);
    bit h;
    h = bo[mb[i]] && br[mb[i]] == mr[i];
    if (ma[i] > nl) return 4;
    if (!mw[i]) return h ? 3 : 2;
    return h ? 1 : 0;
  endfunction

  function automatic bit elig(input int i);
    return mv[i] && bbusy[mb[i]] == 0;
  endfunction

  function automatic bit free_any();
    for (int i = 0; i < DEPTH; i++) if (!mv[i]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic expect_now();
    int best_s, s, ties;
    e_valid = 0; e_idx = 0; e_kind = 0; e_why = "R4"; best_s = -1;
    if (hv) begin
      e_valid = 1; e_idx = hi; e_kind = kind_of(hi); e_why = "R9";
      return;
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (elig(i)) begin
        s = rank_of(i) * 256 + ma[i];
        if (s > best_s) begin best_s = s; e_idx = i; end
      end
    end
    if (best_s >= 0) begin
      e_valid = 1;
      e_kind = kind_of(e_idx);
      ties = 0;
      for (int i = 0; i < DEPTH; i++)
        if (i != e_idx && elig(i) && rank_of(i) == rank_of(e_idx)) ties++;
      case (rank_of(e_idx))
        4: e_why = "R8";
        3: e_why = "R5";
        default: e_why = "R6";
      endcase
      if (ties > 0 && rank_of(e_idx) != 4) e_why = "R7";
    end
  endtask

  task automatic compare();
    chk(req_ready == free_any(), "R1", int'(req_ready), int'(free_any()));
    chk(cmd_valid == e_valid[0], "R4", int'(cmd_valid), e_valid);
    if (cmd_valid && e_valid == 1) begin
      chk(int'(cmd_tag) == e_idx, e_why, int'(cmd_tag), e_idx);
      chk(int'(cmd_kind) == e_kind, "R2", int'(cmd_kind), e_kind);
      chk(int'(cmd_bank) == mb[e_idx] && int'(cmd_row) == mr[e_idx] && int'(cmd_col) == mc[e_idx],
          "R2", int'(cmd_row), mr[e_idx]);
    end
  endtask

  task automatic model_update(input bit rv, input bit rw, input int rb, input int rr,
                              input int rc, input bit crdy);
    int fi, k;
    fi = -1;
    for (int i = DEPTH - 1; i >= 0; i--) if (!mv[i]) fi = i;
    for (int i = 0; i < DEPTH; i++) if (mv[i] && ma[i] < AGE_MAX) ma[i]++;
    for (int b = 0; b < BANKS; b++) if (bbusy[b] > 0) bbusy[b]--;
    if (e_valid == 1 && crdy) begin
      k = mb[e_idx];
      bbusy[k] = nb;
      if (e_kind == 0) begin bo[k] = 1; br[k] = mr[e_idx]; end
      else if (e_kind == 1) bo[k] = 0;
      else mv[e_idx] = 0;
    end
    if (rv && fi >= 0) begin
      mv[fi] = 1; mw[fi] = rw; mb[fi] = rb; mr[fi] = rr; mc[fi] = rc; ma[fi] = 0;
    end
    hv = (e_valid == 1) && !crdy;
    hi = e_idx;
  endtask

  task automatic cycle(input bit rv, input bit rw, input int rb, input int rr,
                       input int rc, input bit crdy);
    @(negedge clk);
    expect_now();
    compare();
    req_valid = rv; req_write = rw;
    req_bank = BANK_W'(rb); req_row = ROW_W'(rr); req_col = COL_W'(rc);
    cmd_ready = crdy;
    cfg_busy = BUSY_W'(nb); cfg_age_limit = AGE_W'(nl);
    expect_now();
    model_update(rv, rw, rb, rr, rc, crdy);
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    hv = 0; hi = 0;
    for (int i = 0; i < DEPTH; i++) begin mv[i] = 0; ma[i] = 0; end
    for (int b = 0; b < BANKS; b++) begin bo[b] = 0; br[b] = 0; bbusy[b] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state
    chk(req_ready == 1'b1, "R11", int'(req_ready), 1);
    chk(cmd_valid == 1'b0, "R11", int'(cmd_valid), 0);

    // R10: second bank proceeds while first bank is blocked
    nb = 4;
    cycle(1, 0, 0, 1, 0, 0);
    cycle(1, 0, 1, 1, 0, 0);
    cycle(0, 0, 0, 0, 0, 1);
    cycle(0, 0, 0, 0, 0, 1);
    chk(cmd_valid && cmd_bank == 3'd1 && cmd_kind == 2'd0, "R10", int'(cmd_bank), 1);
    repeat (20) cycle(0, 0, 0, 0, 0, 1);

    // R1 / R3: fill the pool, then free one slot with a column access
    nb = 0;
    for (int i = 0; i < DEPTH; i++) cycle(1, 0, 2, 3, i, 0);
    cycle(0, 0, 0, 0, 0, 0);
    chk(req_ready == 1'b0, "R1", int'(req_ready), 0);
    cycle(0, 0, 0, 0, 0, 1);
    cycle(0, 0, 0, 0, 0, 1);
    cycle(0, 0, 0, 0, 0, 0);
    chk(req_ready == 1'b1, "R3", int'(req_ready), 1);
    repeat (30) cycle(0, 0, 0, 0, 0, 1);

    // R5/R6: a write and a read hit on the open row of bank 2, plus a read miss
    cycle(1, 1, 2, 3, 9, 0);
    cycle(1, 0, 4, 0, 1, 0);
    cycle(1, 0, 2, 3, 5, 0);
    cycle(0, 0, 0, 0, 0, 1);
    repeat (20) cycle(0, 0, 0, 0, 0, 1);

    // random phases: varying busy count and age limit (R4, R7, R8, R9)
    for (int ph = 0; ph < 6; ph++) begin
      nb = ph % 4;
      nl = (ph == 5) ? AGE_MAX : 3 + ph * 9;
      for (int c = 0; c < 3000; c++) begin
        cycle($urandom_range(0, 9) < 6, $urandom_range(0, 2) == 0,
              int'($urandom_range(0, 3)), int'($urandom_range(0, 2)),
              int'($urandom_range(0, 1023)), $urandom_range(0, 9) < 7);
      end
      repeat (200) cycle(0, 0, 0, 0, 0, 1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule